// File: doc/BRIEF.md
# Sequential Shift-Add Mantissa Multiplier

This block multiplies two unpacked, normalized floating-point mantissas over many clock cycles. Each mantissa is a vector of `N_WORDS` words of `WORD_W` bits. Its leading one sits at bit `MANT_W-1`, and its bottom `GUARD` bits are guard bits. A one-cycle `start` pulse captures both mantissas and two exponents. The block then walks the multiplier one bit per cycle, starting at the least significant bit.

Each step shifts the accumulator right by one bit and adds the multiplicand when the current multiplier bit is set. Every bit that leaves the bottom of the accumulator is ORed into a sticky flag. An all-zero multiplier word is skipped in one cycle with a whole-word shift. Stepping in the top word stops at its highest set bit. A final cycle renormalizes a product of two or more by one bit.

When the work ends, `done` pulses and the outputs hold the following values until the next result:
- the product mantissa;
- the sticky flag;
- the summed exponent.

Special operand classes, rounding and packing are handled outside this block.

Top module: `smul_top`

## Requirements
- R1: A `start` while idle raises `busy` on the next clock edge. `busy` stays high until the cycle in which `done` is high, and in that cycle `busy` is low. `done` is high for exactly one cycle per operation.
- R2: For normalized inputs, the product mantissa equals floor(X*Y / 2^(MANT_W-1)). If that value is 2^MANT_W or more, it is shifted right by one more bit, so the result always has its leading one at bit `MANT_W-1`.
- R3: `p_sticky` is the OR of every product bit discarded below the returned mantissa, including the bit lost in renormalization.
- R4: `p_exp` equals `x_exp + y_exp`, modulo 2^EXP_W, plus one when renormalization took place.
- R5: A `start` pulse while `busy` is high is ignored. The running operation finishes with its original operands.
- R6: Latency is the number of clock edges from the edge that captures `start` to the first cycle where `done` is high. It equals 1 plus the sum of the per-word costs below. Words are numbered from the least significant.
  - Any zero word costs 1.
  - A nonzero word 0 costs `WORD_W-GUARD`, because stepping starts above the guard bits.
  - A nonzero middle word costs `WORD_W`.
  - The nonzero top word costs its highest set bit index plus 1.
- R7: Skipping a zero multiplier word gives the same mantissa and sticky as stepping through it bit by bit. This holds both for a zero lowest word and for zero middle words.
- R8: After reset, `busy`, `done`, `p_mant`, `p_sticky` and `p_exp` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| x_mant | input | WORD_W*N_WORDS | Multiplicand mantissa |
| y_mant | input | WORD_W*N_WORDS | Multiplier mantissa, guard bits zero |
| x_exp | input | EXP_W | Multiplicand exponent, two's complement |
| y_exp | input | EXP_W | Multiplier exponent, two's complement |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| p_mant | output | WORD_W*N_WORDS | Product mantissa |
| p_sticky | output | 1 | OR of discarded product bits |
| p_exp | output | EXP_W | Product exponent |

## Verification
The bench targets the following corner cases:
- **Unit operands and zero low multiplier words.** A design that shifted the still-empty accumulator for a zero lowest word, or that dropped the word moved out on a skip, would return a wrong mantissa, a wrong sticky or a wrong latency.
- **All-ones operands.** These force renormalization. A missed extra shift leaves the leading one one place too high and the exponent one too low.
- **Mismatched exponent signs and a `start` pulse issued mid-operation.** These catch exponent wrap errors and operands corrupted while busy.
- **Random mantissas.** Their cycle counts expose any off-by-one in where stepping begins or stops inside a word.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_STEP = 2'd1,
    OP_SKIP = 2'd2,
    OP_NORM = 2'd3
  } smul_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_NORM = 2'd2
  } smul_state_e;
endpackage

// File: rtl/smul_acc_unit.sv
module smul_acc_unit
  import smul_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 4,
  parameter int MANT_W  = 115
) (
  input  smul_op_e                      op,
  input  logic                          add_en,
  input  logic [WORD_W*N_WORDS-1:0]     acc_i,
  input  logic                          sticky_i,
  input  logic [WORD_W*N_WORDS-1:0]     mcand,
  output logic [WORD_W*N_WORDS-1:0]     acc_o,
  output logic                          sticky_o,
  output logic                          norm_inc
);
  localparam int TOT_W = WORD_W * N_WORDS;

  always_comb begin
    acc_o    = acc_i;
    sticky_o = sticky_i;
    norm_inc = 1'b0;
    case (op)
      OP_STEP: begin
        acc_o    = (acc_i >> 1) + (add_en ? mcand : {TOT_W{1'b0}});
        sticky_o = sticky_i | acc_i[0];
      end
      OP_SKIP: begin
        acc_o    = acc_i >> WORD_W;
        sticky_o = sticky_i | (|acc_i[WORD_W-1:0]);
      end
      OP_NORM: begin
        if (acc_i[MANT_W]) begin
          acc_o    = acc_i >> 1;
          sticky_o = sticky_i | acc_i[0];
          norm_inc = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/smul_seq_ctrl.sv
module smul_seq_ctrl
  import smul_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 4,
  parameter int GUARD   = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [WORD_W*N_WORDS-1:0] y_words,
  output logic                      busy,
  output logic                      load,
  output smul_op_e                  op,
  output logic                      add_bit
);
  localparam int WI_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
  localparam int BI_W = $clog2(WORD_W);
  localparam logic [WI_W-1:0] LAST_W  = WI_W'(N_WORDS - 1);
  localparam logic [BI_W-1:0] TOP_BIT = BI_W'(WORD_W - 1);

  smul_state_e     state;
  logic [WI_W-1:0] widx;
  logic [BI_W-1:0] bidx;
  logic [WORD_W-1:0] cur_word;
  logic            word_zero, hi_clear, word_end;

  assign cur_word  = y_words[int'(widx)*WORD_W +: WORD_W];
  assign word_zero = (cur_word == '0);
  assign hi_clear  = (((cur_word >> bidx) >> 1) == '0);
  assign word_end  = word_zero || ((widx == LAST_W) ? hi_clear : (bidx == TOP_BIT));
  assign busy      = (state != ST_IDLE);
  assign load      = (state == ST_IDLE) && start;

  always_comb begin
    op      = OP_NONE;
    add_bit = 1'b0;
    case (state)
      ST_RUN: begin
        if (word_zero) begin
          op = (widx == '0) ? OP_NONE : OP_SKIP;
        end else begin
          op      = OP_STEP;
          add_bit = cur_word[bidx];
        end
      end
      ST_NORM: op = OP_NORM;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      widx  <= '0;
      bidx  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_RUN;
          widx  <= '0;
          bidx  <= BI_W'(GUARD);
        end
        ST_RUN: begin
          if (word_end) begin
            bidx <= '0;
            if (widx == LAST_W) state <= ST_NORM;
            else widx <= widx + 1'b1;
          end else begin
            bidx <= bidx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: stepping in the lowest word never touches the guard bits
  a_r6_skip_guard: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && widx == '0 && !word_zero) |-> (bidx >= BI_W'(GUARD)));

  // R1: the renormalization cycle is always followed by idle
  a_r1_norm_to_idle: assert property (@(posedge clk) disable iff (rst)
    (state == ST_NORM) |=> (state == ST_IDLE));
endmodule

// File: rtl/smul_top.sv
module smul_top
  import smul_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 4,
  parameter int MANT_W  = 115,
  parameter int GUARD   = 2,
  parameter int EXP_W   = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [WORD_W*N_WORDS-1:0] x_mant,
  input  logic [WORD_W*N_WORDS-1:0] y_mant,
  input  logic [EXP_W-1:0]          x_exp,
  input  logic [EXP_W-1:0]          y_exp,
  output logic                      busy,
  output logic                      done,
  output logic [WORD_W*N_WORDS-1:0] p_mant,
  output logic                      p_sticky,
  output logic [EXP_W-1:0]          p_exp
);
  localparam int TOT_W = WORD_W * N_WORDS;

  logic [TOT_W-1:0] x_q, y_q, acc_q, acc_n;
  logic [EXP_W-1:0] esum_q;
  logic             stk_q, stk_n, norm_inc, load, add_bit;
  smul_op_e         op;

  smul_seq_ctrl #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .GUARD(GUARD)) i_ctrl (
    .clk(clk), .rst(rst), .start(start), .y_words(y_q),
    .busy(busy), .load(load), .op(op), .add_bit(add_bit)
  );

  smul_acc_unit #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .MANT_W(MANT_W)) i_acc (
    .op(op), .add_en(add_bit), .acc_i(acc_q), .sticky_i(stk_q), .mcand(x_q),
    .acc_o(acc_n), .sticky_o(stk_n), .norm_inc(norm_inc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q      <= '0;
      y_q      <= '0;
      esum_q   <= '0;
      acc_q    <= '0;
      stk_q    <= 1'b0;
      done     <= 1'b0;
      p_mant   <= '0;
      p_sticky <= 1'b0;
      p_exp    <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        x_q    <= x_mant;
        y_q    <= y_mant;
        esum_q <= x_exp + y_exp;
        acc_q  <= '0;
        stk_q  <= 1'b0;
      end else if (op == OP_STEP || op == OP_SKIP) begin
        acc_q <= acc_n;
        stk_q <= stk_n;
      end
      if (op == OP_NORM) begin
        p_mant   <= acc_n;
        p_sticky <= stk_n;
        p_exp    <= esum_q + EXP_W'(norm_inc);
        done     <= 1'b1;
      end
    end
  end

  a_r1_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r1_idle_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r5_operands_held: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(y_q) && $stable(x_q) && $stable(esum_q)));

  a_r3_sticky_kept: assert property (@(posedge clk) disable iff (rst)
    (busy && stk_q) |=> stk_q);

  a_r4_exp_sum: assert property (@(posedge clk) disable iff (rst)
    done |-> (p_exp == esum_q || p_exp == esum_q + EXP_W'(1)));

  a_r2_normalized: assert property (@(posedge clk) disable iff (rst)
    (done && x_q[MANT_W-1] && y_q[MANT_W-1] && (x_q >> MANT_W) == '0 && (y_q >> MANT_W) == '0)
      |-> (p_mant[MANT_W-1] && (p_mant >> MANT_W) == '0));
endmodule

// File: tb/test_smul_top.sv
module test_smul_top;
  localparam int WORD_W  = 32;
  localparam int N_WORDS = 4;
  localparam int MANT_W  = 115;
  localparam int GUARD   = 2;
  localparam int EXP_W   = 12;
  localparam int TOT_W   = WORD_W * N_WORDS;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [TOT_W-1:0] x_mant = '0, y_mant = '0, p_mant;
  logic [EXP_W-1:0] x_exp = '0, y_exp = '0, p_exp;
  logic busy, done, p_sticky;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  smul_top #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .MANT_W(MANT_W), .GUARD(GUARD), .EXP_W(EXP_W)) i_smul_top (
    .clk(clk), .rst(rst), .start(start), .x_mant(x_mant), .y_mant(y_mant),
    .x_exp(x_exp), .y_exp(y_exp), .busy(busy), .done(done),
    .p_mant(p_mant), .p_sticky(p_sticky), .p_exp(p_exp)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [TOT_W-1:0] got, input logic [TOT_W-1:0] exp_v);
    total++;
    if (got !== exp_v) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp_v);
    end
  endtask

  function automatic logic [TOT_W-1:0] norm_val(input logic [TOT_W-1:0] v);
    logic [TOT_W-1:0] r;
    r = v & ((TOT_W'(1) << MANT_W) - 1);
    r[MANT_W-1] = 1'b1;
    r[GUARD-1:0] = '0;
    return r;
  endfunction

  function automatic logic [TOT_W-1:0] rnd_wide();
    logic [TOT_W-1:0] r;
    for (int i = 0; i < N_WORDS; i++) r[i*WORD_W +: WORD_W] = $urandom;
    return r;
  endfunction

  // expected result from the product definition (R2, R3, R4)
  task automatic ref_mul(input logic [TOT_W-1:0] x, input logic [TOT_W-1:0] y,
                         output logic [TOT_W-1:0] m, output logic st, output logic inc);
    logic [2*TOT_W-1:0] p, sh;
    p  = {{TOT_W{1'b0}}, x} * {{TOT_W{1'b0}}, y};
    sh = p >> (MANT_W - 1);
    st = |p[MANT_W-2:0];
    inc = 1'b0;
    if (sh[MANT_W]) begin
      st  = st | sh[0];
      sh  = sh >> 1;
      inc = 1'b1;
    end
    m = sh[TOT_W-1:0];
  endtask

  // expected latency (R6)
  function automatic int ref_lat(input logic [TOT_W-1:0] y);
    int n = 1;
    for (int w = 0; w < N_WORDS; w++) begin
      logic [WORD_W-1:0] wd = y[w*WORD_W +: WORD_W];
      if (wd == '0) n += 1;
      else if (w == 0) n += WORD_W - GUARD;
      else if (w < N_WORDS - 1) n += WORD_W;
      else begin
        int hi = 0;
        for (int b = 0; b < WORD_W; b++) if (wd[b]) hi = b;
        n += hi + 1;
      end
    end
    return n;
  endfunction

  task automatic run_op(input string tag, input logic [TOT_W-1:0] x, input logic [TOT_W-1:0] y,
                        input logic [EXP_W-1:0] ex, input logic [EXP_W-1:0] ey, input bit poke);
    logic [TOT_W-1:0] em;
    logic est, inc;
    int cnt = 0;
    ref_mul(x, y, em, est, inc);
    @(negedge clk);
    x_mant = x; y_mant = y; x_exp = ex; y_exp = ey; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cnt < 5000) begin
      if (poke && cnt == 3) begin
        // R5: a second start while busy must be ignored
        x_mant = ~x; y_mant = norm_val(~y); x_exp = ~ex; y_exp = ey + 1'b1; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      cnt++;
      if (cnt == 1) check({tag, " R1 busy raised"}, TOT_W'(busy), TOT_W'(1));
    end
    check({tag, " R1 busy low at done"}, TOT_W'(busy), TOT_W'(0));
    check({tag, " R6 latency"}, TOT_W'(cnt), TOT_W'(ref_lat(y)));
    check({tag, " R2 mantissa"}, p_mant, em);
    check({tag, " R3 sticky"}, TOT_W'(p_sticky), TOT_W'(est));
    check({tag, " R4 exponent"}, TOT_W'(p_exp), TOT_W'(EXP_W'(ex + ey + EXP_W'(inc))));
    @(negedge clk);
    check({tag, " R1 done one cycle"}, TOT_W'(done), TOT_W'(0));
    check({tag, " R2 result held"}, p_mant, em);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected<=200000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [TOT_W-1:0] one, ones, xr, yr;
    void'($urandom(32'd1234));
    one  = TOT_W'(1) << (MANT_W - 1);
    ones = norm_val('1);
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 busy", TOT_W'(busy), TOT_W'(0));
    check("R8 done", TOT_W'(done), TOT_W'(0));
    check("R8 mant", p_mant, '0);
    check("R8 sticky exp", TOT_W'({p_sticky, p_exp}), '0);
    rst = 1'b0;

    run_op("unit*unit R7", one, one, 12'd3, 12'd4, 1'b0);
    run_op("max*max", ones, ones, 12'd10, 12'd20, 1'b0);
    run_op("neg exps", ones, one, -12'sd5, -12'sd7, 1'b0);
    xr = norm_val(rnd_wide());
    run_op("R7 low word only", xr, one | (TOT_W'(32'h8000_0004)), 12'd1, 12'd2, 1'b0);
    run_op("R7 mid zero", xr, one | (TOT_W'(32'h0000_0010)) | (TOT_W'(32'h1) << (2*WORD_W)), 12'd0, 12'd0, 1'b0);
    run_op("R5 poke", norm_val(rnd_wide()), norm_val(rnd_wide()), 12'd100, -12'sd50, 1'b1);

    for (int i = 0; i < 60; i++) begin
      xr = norm_val(rnd_wide());
      yr = norm_val(rnd_wide());
      for (int w = 0; w < N_WORDS - 1; w++)
        if ($urandom_range(2) == 0) yr[w*WORD_W +: WORD_W] = '0;
      run_op("random", xr, yr, EXP_W'($urandom), EXP_W'($urandom), (i % 10) == 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule